// File: doc/BRIEF.md
# Streaming Copy-and-Checksum Verifier

This engine moves a firmware image from a source memory to a destination memory, one 32-bit word at a time. It also proves that the image is intact during that same pass. Each word is added to a running 32-bit wrap-around sum at the moment it is fetched. The image carries a correcting word somewhere near its tail, and that word is summed like any other. An intact image therefore totals zero. After the final word has been handled, the engine checks the total once and reports the outcome. A zero total is a pass. Any other total is a fail, and the engine posts a fixed self-test error code.

Software or a boot sequencer starts a run with a one-cycle start pulse, which carries the source base, the destination base and the length in words. The verify-only mode reads and sums the image where it lies and writes nothing. This lets a stage be checked in place before control passes to it. Both memory sides use valid/ready handshakes and may stall for any number of cycles.

Top module: `image_copy_verifier`

## Requirements
- R1: The result is the sum modulo 2^32 of every image word. A zero sum sets `pass`=1 and `err_code`=0. A nonzero sum sets `pass`=0 and `err_code`=FAIL_CODE, which defaults to 8'hE1.
- R2: In copy mode, word i is read from address `src_base`+i and written to `dst_base`+i with unchanged data. Word i is written before word i+1 is read, so exactly `len_words` reads and `len_words` writes occur.
- R3: A read request holds `rd_valid` and `rd_addr` until `rd_ready` is high. A write holds `wr_valid`, `wr_addr` and `wr_data` until `wr_ready` is high. No word is lost or repeated under any pattern of stalls.
- R4: The zero test is applied once, after the last word completes. `done` is high for exactly one cycle. `pass` and `err_code` then hold until the next accepted start.
- R5: A start with `len_words`=0 raises `done` on the next clock edge with `pass`=1 and `err_code`=0, and issues no memory request.
- R6: A start pulse that arrives while `busy` is high is ignored. The run in progress keeps its addresses, its length, its mode and its result.
- R7: With `verify_only`=1 at start, the engine performs the same reads and the same summation, and `wr_valid` never rises.
- R8: `busy` is high from the clock edge that accepts a nonzero-length start until the edge that raises `done`. `busy` is low while `done` is high.
- R9: After reset, `busy`, `done`, `pass`, `err_code`, `rd_valid`, `rd_data_ready` and `wr_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| verify_only | input | 1 | 1: sum only, no writes |
| src_base | input | ADDR_W | First source word address |
| dst_base | input | ADDR_W | First destination word address |
| len_words | input | LEN_W | Image length in 32-bit words |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last run summed to zero |
| err_code | output | ERR_W | 0 on pass, FAIL_CODE on fail |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Source accepts read request |
| rd_addr | output | ADDR_W | Read word address |
| rd_data_valid | input | 1 | Read data valid |
| rd_data_ready | output | 1 | Engine accepts read data |
| rd_data | input | 32 | Read data word |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Destination accepts write |
| wr_addr | output | ADDR_W | Write word address |
| wr_data | output | 32 | Write data word |

## Verification
A corrupted accumulator or a skipped word shows up only once, as a wrong `pass` or `err_code` in the single `done` cycle. For that reason every image is built with a known sum, and both a zero-sum case and an off-by-one case are run. A wrong index or held word shows up immediately on the memory ports, as an address or data word out of order on the next handshake. The bench compares every handshake against the expected sequence. A broken stall path shows up as a missing or duplicated beat under the alternating and pseudo-random ready patterns.

// File: rtl/icv_pkg.sv
package icv_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RREQ,
    ST_RRSP,
    ST_WR,
    ST_FIN
  } icv_state_e;

  // wrap-around accumulation: carries out of the top bit are dropped
  function automatic logic [WORD_W-1:0] wrap_add(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic is_zero_sum(input logic [WORD_W-1:0] s);
    return s == '0;
  endfunction
endpackage

// File: rtl/icv_index_ctr.sv
module icv_index_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] idx,
  output logic             last
);
  logic [LEN_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (clr)  idx_q <= '0;
    else if (step) idx_q <= idx_q + 1'b1;
  end

  assign idx  = idx_q;
  assign last = (idx_q + 1'b1) == len;

  // R2: the word index never runs past the image length
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= len);
endmodule

// File: rtl/icv_sum_acc.sv
module icv_sum_acc
  import icv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] sum,
  output logic              zero
);
  logic [WORD_W-1:0] sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (clr)    sum_q <= '0;
    else if (add_en) sum_q <= wrap_add(sum_q, word);
  end

  assign sum  = sum_q;
  assign zero = is_zero_sum(sum_q);

  // R1: every run starts from an empty sum
  a_r1_sum_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> sum_q == '0);
endmodule

// File: rtl/icv_word_hold.sv
module icv_word_hold
  import icv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/image_copy_verifier.sv
module image_copy_verifier
  import icv_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter int               LEN_W     = 16,
  parameter int               ERR_W     = 8,
  parameter logic [ERR_W-1:0] FAIL_CODE = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              verify_only,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [LEN_W-1:0]  len_words,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ERR_W-1:0]  err_code,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_data_valid,
  output logic              rd_data_ready,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  icv_state_e st, st_n;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;
  logic              verify_q;

  // named internal events
  logic              accept;
  logic              accept_empty;
  logic              beat_in;
  logic              step;
  logic              last;
  logic              sum_zero;
  logic [LEN_W-1:0]  idx;
  logic [WORD_W-1:0] sum;
  logic [WORD_W-1:0] held;

  assign accept       = (st == ST_IDLE) && start;
  assign accept_empty = accept && (len_words == '0);
  assign beat_in      = (st == ST_RRSP) && rd_data_valid;
  assign step         = ((st == ST_WR) && wr_ready) || (beat_in && verify_q);

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: if (accept && !accept_empty) st_n = ST_RREQ;
      ST_RREQ: if (rd_ready) st_n = ST_RRSP;
      ST_RRSP: if (rd_data_valid) begin
        if (!verify_q)  st_n = ST_WR;
        else if (last)  st_n = ST_FIN;
        else            st_n = ST_RREQ;
      end
      ST_WR:   if (wr_ready) st_n = last ? ST_FIN : ST_RREQ;
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      len_q    <= '0;
      verify_q <= 1'b0;
    end else begin
      st <= st_n;
      if (accept) begin
        src_q    <= src_base;
        dst_q    <= dst_base;
        len_q    <= len_words;
        verify_q <= verify_only;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      pass     <= 1'b0;
      err_code <= '0;
    end else begin
      done <= 1'b0;
      if (accept_empty) begin
        done     <= 1'b1;
        pass     <= 1'b1;
        err_code <= '0;
      end else if (accept) begin
        pass     <= 1'b0;
        err_code <= '0;
      end else if (st == ST_FIN) begin
        done     <= 1'b1;
        pass     <= sum_zero;
        err_code <= sum_zero ? '0 : FAIL_CODE;
      end
    end
  end

  icv_index_ctr #(.LEN_W(LEN_W)) u_idx (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .step (step),
    .len  (len_q),
    .idx  (idx),
    .last (last)
  );

  icv_sum_acc u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .add_en(beat_in),
    .word  (rd_data),
    .sum   (sum),
    .zero  (sum_zero)
  );

  icv_word_hold u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (beat_in),
    .din  (rd_data),
    .dout (held)
  );

  assign busy          = (st != ST_IDLE);
  assign rd_valid      = (st == ST_RREQ);
  assign rd_data_ready = (st == ST_RRSP);
  assign wr_valid      = (st == ST_WR);
  assign rd_addr       = src_q + ADDR_W'(idx);
  assign wr_addr       = dst_q + ADDR_W'(idx);
  assign wr_data       = held;

  // R3: a stalled read request holds its address
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  // R3: a stalled write holds its address and data
  a_r3_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R4: completion is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: the error code agrees with the verdict
  a_r1_code_pass: assert property (@(posedge clk) disable iff (!rst_n)
    done && pass |-> err_code == '0);
  a_r1_code_fail: assert property (@(posedge clk) disable iff (!rst_n)
    done && !pass |-> err_code == FAIL_CODE);
  // R6: a start during a run leaves the captured job untouched
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(len_q) && $stable(src_q) && $stable(verify_q));
  // R7: verify-only runs never write
  a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy && verify_q |-> !wr_valid);
  // R8: busy has dropped by the time done is shown
  a_r8_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2: at most one memory channel is active at a time
  a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, rd_data_ready, wr_valid}));
endmodule

// File: tb/tb_image_copy_verifier.sv
module tb_image_copy_verifier;
  localparam int         AW    = 8;
  localparam int         LW    = 6;
  localparam logic [7:0] FAILC = 8'hE1;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0, verify_only = 0;
  logic [AW-1:0] src_base = 0, dst_base = 0;
  logic [LW-1:0] len_words = 0;
  logic          busy, done, pass;
  logic [7:0]    err_code;
  logic          rd_valid, rd_ready, rd_data_valid, rd_data_ready;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0]   rd_data, wr_data;
  logic          wr_valid, wr_ready;

  always #5 clk = ~clk;

  image_copy_verifier #(.ADDR_W(AW), .LEN_W(LW), .ERR_W(8), .FAIL_CODE(FAILC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .verify_only(verify_only),
    .src_base(src_base), .dst_base(dst_base), .len_words(len_words),
    .busy(busy), .done(done), .pass(pass), .err_code(err_code),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_data_valid(rd_data_valid), .rd_data_ready(rd_data_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [256];
  logic [31:0] img [64];
  logic [AW-1:0] exp_src, exp_dst;
  int rd_cnt, wr_cnt, order_err, stall_mode;
  logic [15:0] lf = 16'hACE1;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit gate(input int salt);
    if (stall_mode == 0) return 1'b1;
    if (stall_mode == 1) return ((n_chk + salt + int'(lf[0])) % 2) == 0;
    return lf[salt*3] | lf[salt*3+1];
  endfunction

  function automatic logic [31:0] next_rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // memory model: acts on the handshakes of the previous edge, then drives the next
  initial begin
    bit rd_hs = 0, rsp_hs = 0, wr_hs = 0, pend = 0;
    logic [AW-1:0] hs_ra = 0, hs_wa = 0, pend_a = 0;
    logic [31:0]   hs_wd = 0;
    rd_ready = 0; wr_ready = 0; rd_data_valid = 0; rd_data = 0;
    forever begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (rsp_hs) pend = 0;
      if (rd_hs) begin
        if (hs_ra != AW'(exp_src + AW'(rd_cnt))) order_err++;
        rd_cnt++; pend = 1; pend_a = hs_ra;
      end
      if (wr_hs) begin
        if (hs_wa != AW'(exp_dst + AW'(wr_cnt)) || hs_wd != img[wr_cnt[5:0]]) order_err++;
        mem[hs_wa] = hs_wd; wr_cnt++;
      end
      rd_ready      = gate(0);
      wr_ready      = gate(1);
      rd_data_valid = pend && gate(2);
      rd_data       = pend ? mem[pend_a] : 32'h0;
      rd_hs  = rd_valid && rd_ready;       hs_ra = rd_addr;
      rsp_hs = rd_data_valid && rd_data_ready;
      wr_hs  = wr_valid && wr_ready;       hs_wa = wr_addr; hs_wd = wr_data;
    end
  end

  task automatic pulse_start(input int len, input bit vo, input logic [AW-1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    start = 1; verify_only = vo; len_words = LW'(len); src_base = s; dst_base = d;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_case(input int len, input bit vo, input bit bad, input int smode, input bit inject);
    logic [31:0] s, exp_sum;
    bit exp_pass;
    int pos, cnt, mism;
    for (int i = 0; i < len; i++) img[i] = next_rnd();
    pos = (len >= 4) ? len - 4 : len - 1;
    s = 0;
    for (int i = 0; i < len; i++) if (i != pos) s = s + img[i];
    img[pos] = 32'h0 - s;
    if (bad) img[0] = img[0] + 32'h1;
    exp_sum = 0;
    for (int i = 0; i < len; i++) exp_sum = exp_sum + img[i];
    exp_pass = (exp_sum == 0);
    @(negedge clk);
    exp_src = AW'(4 + len % 4); exp_dst = 8'h80;
    for (int i = 0; i < len; i++) begin
      mem[exp_src + AW'(i)] = img[i];
      mem[exp_dst + AW'(i)] = 32'hD0D0_0000 | i;
    end
    rd_cnt = 0; wr_cnt = 0; order_err = 0; stall_mode = smode;
    pulse_start(len, vo, exp_src, exp_dst);
    chk(busy == 1, "R8 busy after start", 32'(busy), 1);
    if (inject) begin
      repeat (3) @(negedge clk);
      start = 1; verify_only = ~vo; len_words = 2; src_base = 8'h60; dst_base = 8'h40;
      @(negedge clk);
      start = 0;
    end
    cnt = 0;
    while (!done && cnt < 4000) begin @(negedge clk); cnt++; end
    chk(done == 1, "R4 done reached", 32'(done), 1);
    chk(pass == exp_pass, "R1 pass verdict", 32'(pass), 32'(exp_pass));
    chk(err_code == (exp_pass ? 8'h0 : FAILC), "R1 error code", 32'(err_code), 32'(exp_pass ? 8'h0 : FAILC));
    chk(busy == 0, "R8 busy low at done", 32'(busy), 0);
    chk(rd_cnt == len, inject ? "R6 read count" : "R2 read count", 32'(rd_cnt), 32'(len));
    chk(order_err == 0, smode != 0 ? "R3 beats under stall" : "R2 beat order", 32'(order_err), 0);
    mism = 0;
    for (int i = 0; i < len; i++)
      if (mem[exp_dst + AW'(i)] != (vo ? (32'hD0D0_0000 | i) : img[i])) mism++;
    if (vo) begin
      chk(wr_cnt == 0, "R7 no writes", 32'(wr_cnt), 0);
      chk(mism == 0, "R7 destination untouched", 32'(mism), 0);
    end else begin
      chk(wr_cnt == len, inject ? "R6 write count" : "R2 write count", 32'(wr_cnt), 32'(len));
      chk(mism == 0, "R2 destination contents", 32'(mism), 0);
    end
    @(negedge clk);
    chk(done == 0, "R4 single pulse", 32'(done), 0);
    chk(pass == exp_pass, "R4 verdict held", 32'(pass), 32'(exp_pass));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    exp_src = 0; exp_dst = 0; rd_cnt = 0; wr_cnt = 0; order_err = 0; stall_mode = 0;
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && pass == 0 && err_code == 0, "R9 reset outputs",
        {busy, done, pass, err_code}, 0);
    chk(rd_valid == 0 && rd_data_ready == 0 && wr_valid == 0, "R9 reset handshakes",
        {rd_valid, rd_data_ready, wr_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int sm = 0; sm < 3; sm++)
      for (int len = 1; len <= 10; len++)
        for (int k = 0; k < 4; k++)
          run_case(len, k[1], k[0], sm, 1'b0);
    run_case(63, 1'b0, 1'b0, 2, 1'b0);
    run_case(63, 1'b1, 1'b1, 1, 1'b0);

    // R6: start during a run, with a different length and mode
    run_case(6, 1'b0, 1'b1, 1, 1'b1);
    run_case(5, 1'b1, 1'b0, 2, 1'b1);

    // R5: empty image after a failing run
    run_case(3, 1'b0, 1'b1, 0, 1'b0);
    rd_cnt = 0; wr_cnt = 0;
    pulse_start(0, 1'b0, 8'h10, 8'h80);
    chk(done == 1, "R5 done next edge", 32'(done), 1);
    chk(pass == 1 && err_code == 0, "R5 empty passes", {pass, err_code}, 32'h100);
    chk(busy == 0, "R5 not busy", 32'(busy), 0);
    @(negedge clk);
    chk(rd_cnt == 0 && wr_cnt == 0, "R5 no memory traffic", 32'(rd_cnt + wr_cnt), 0);
    chk(done == 0, "R4 empty pulse width", 32'(done), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule